// File: doc/BRIEF.md
# Multiply result interlock detector

This block is the hazard logic for a five-stage in-order pipeline. The multiplier spans the Execute and Memory stages, so its product only exists at the end of Memory. The block watches the instruction waiting in Decode. When that instruction needs the product of the multiply that has just gone into Execute, the block raises a one-cycle stall request. That request holds Fetch and Decode and puts a bubble into Execute.

There is one case with no stall. The instruction is a multiply-accumulate that takes the previous product as its late accumulator operand. In that case the block selects the multiplier's internal accumulate feedback path instead. The block keeps a record of the multiply in Execute by itself, using the instructions it lets through. The register file and the multiplier are outside the block.

Top module: `mul_hazard_unit`

## Requirements
- R1: After reset, no producer is recorded. An instruction in Decode that reads any register gets no stall.
- R2: An instruction reads the destination of the multiply immediately before it through an early source (late flag 0, needed in the first Execute cycle). It gets a stall of exactly one cycle.
- R3: An instruction that is not a multiply-accumulate reads the product through a late source (late flag 1, needed in the first Memory cycle, such as store data in slot 2). It also gets a stall of exactly one cycle.
- R4: A multiply-accumulate (id_is_mla=1) takes the previous product through source slot 2 with late flag 1. This is the accumulator slot. It gets no stall, and acc_fwd_sel is 1 in that cycle.
- R5: A chained multiply-accumulate also reads the previous product through slot 0 or slot 1. It gets a stall, because only the accumulator slot is exempt.
- R6: Both plain multiplies and multiply-accumulates count as producers.
- R7: The following never start an interlock: a producer whose destination is the program counter (register 2**REG_W-1), an instruction without a destination, and any instruction that is not a multiply.
- R8: An instruction two or more slots after the multiply never stalls on it. After a stall, the held instruction proceeds in the next cycle.
- R9: When id_valid is 0, stall and acc_fwd_sel are both 0, and no producer is recorded.
- R10: acc_fwd_sel is never 1 in a cycle in which stall is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode holds a real instruction |
| id_is_mul | input | 1 | Decode instruction is a multiply of either kind |
| id_is_mla | input | 1 | Decode instruction is a multiply-accumulate |
| id_has_dst | input | 1 | Decode instruction writes a register |
| id_dst | input | REG_W | Destination register index |
| id_src_en | input | NUM_SRC | Per-slot source read enable |
| id_src_late | input | NUM_SRC | Per-slot need stage: 0 first Execute, 1 first Memory |
| id_src_reg | input | NUM_SRC*REG_W | Slot s register index at bits [s*REG_W +: REG_W]; slot 2 is accumulator / store data |
| stall | output | 1 | Hold Fetch and Decode, insert a bubble |
| acc_fwd_sel | output | 1 | Take the accumulator from the multiplier feedback path |

## Verification
The bench builds the block with its default parameters. Those are a 4-bit register index, which puts the program counter at index 15, and three source slots with slot 2 as the accumulator slot. These values cover every case: the program-counter exemption, the choice between an early and a late need, and a chained accumulate that also reads the product through A or B. A behavioural model of the previous accepted instruction predicts stall and acc_fwd_sel on every cycle. The bench also counts the stall cycles for each instruction pair.

// File: rtl/mhz_pkg.sv
// Package: shared verdict encoding for the multiply interlock detector.
// Assumes: consumers only compare against the named values.
package mhz_pkg;
    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_STALL = 2'd1,
        HIT_FEED  = 2'd2
    } hit_e;
endpackage

// File: rtl/mhz_producer_track.sv
// Module: records the multiply that has just entered Execute.
// Assumes: a stall turns the Execute slot into a bubble, and non-multiplies
// or program-counter destinations never need tracking.
module mhz_producer_track #(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic             id_is_mul,
    input  logic             id_has_dst,
    input  logic [REG_W-1:0] id_dst,
    input  logic             stall,
    output logic             prod_valid,
    output logic [REG_W-1:0] prod_dst
);
    localparam logic [REG_W-1:0] PC_REG = {REG_W{1'b1}};

    logic qualifies;

    // Decide whether the Decode instruction becomes a tracked producer.
    always_comb begin
        qualifies = id_valid && id_is_mul && id_has_dst && (id_dst != PC_REG);
    end

    // Advance the Execute-slot record; a stall leaves a bubble behind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_valid <= 1'b0;
            prod_dst   <= '0;
        end else if (stall) begin
            prod_valid <= 1'b0;
            prod_dst   <= prod_dst;
        end else begin
            prod_valid <= qualifies;
            prod_dst   <= id_dst;
        end
    end
endmodule

// File: rtl/mhz_src_match.sv
// Module: classifies one source slot against the recorded producer.
// Assumes: only the accumulator slot of a multiply-accumulate, read late,
// may take the multiplier feedback path.
module mhz_src_match
    import mhz_pkg::*;
#(
    parameter int REG_W       = 4,
    parameter bit IS_ACC_SLOT = 1'b0
) (
    input  logic             prod_valid,
    input  logic [REG_W-1:0] prod_dst,
    input  logic             src_en,
    input  logic             src_late,
    input  logic [REG_W-1:0] src_reg,
    input  logic             id_is_mla,
    output hit_e             hit
);
    logic depends;
    logic feed_ok;

    // Detect a read of the in-flight product and pick stall or feedback.
    always_comb begin
        depends = prod_valid && src_en && (src_reg == prod_dst);
        feed_ok = IS_ACC_SLOT && id_is_mla && src_late;
        if (!depends)
            hit = HIT_NONE;
        else if (feed_ok)
            hit = HIT_FEED;
        else
            hit = HIT_STALL;
    end
endmodule

// File: rtl/mhz_verdict_merge.sv
// Module: merges per-slot verdicts into the stall and feedback outputs.
// Assumes: any stalling slot wins over feedback; an invalid slot in Decode
// asks for nothing.
module mhz_verdict_merge #(
    parameter int NUM_SRC = 3
) (
    input  logic               id_valid,
    input  logic [NUM_SRC-1:0] stall_vec,
    input  logic [NUM_SRC-1:0] feed_vec,
    output logic               stall,
    output logic               acc_fwd_sel
);
    // Reduce the slot vectors to the two block outputs.
    always_comb begin
        stall       = id_valid && (|stall_vec);
        acc_fwd_sel = id_valid && !(|stall_vec) && (|feed_vec);
    end
endmodule

// File: rtl/mul_hazard_unit.sv
// Module: top of the multiply result interlock detector.
// Assumes: the pipeline holds Decode while stall is high; the slot at
// index NUM_SRC-1 carries the accumulator or store data.
module mul_hazard_unit
    import mhz_pkg::*;
#(
    parameter int REG_W   = 4,
    parameter int NUM_SRC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     id_valid,
    input  logic                     id_is_mul,
    input  logic                     id_is_mla,
    input  logic                     id_has_dst,
    input  logic [REG_W-1:0]         id_dst,
    input  logic [NUM_SRC-1:0]       id_src_en,
    input  logic [NUM_SRC-1:0]       id_src_late,
    input  logic [NUM_SRC*REG_W-1:0] id_src_reg,
    output logic                     stall,
    output logic                     acc_fwd_sel
);
    localparam int ACC_SLOT = NUM_SRC - 1;

    logic               prod_valid;
    logic [REG_W-1:0]   prod_dst;
    logic [NUM_SRC-1:0] stall_vec;
    logic [NUM_SRC-1:0] feed_vec;

    mhz_producer_track #(.REG_W(REG_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_valid   (id_valid),
        .id_is_mul  (id_is_mul),
        .id_has_dst (id_has_dst),
        .id_dst     (id_dst),
        .stall      (stall),
        .prod_valid (prod_valid),
        .prod_dst   (prod_dst)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        hit_e hit;
        mhz_src_match #(
            .REG_W       (REG_W),
            .IS_ACC_SLOT (s == ACC_SLOT)
        ) u_match (
            .prod_valid (prod_valid),
            .prod_dst   (prod_dst),
            .src_en     (id_src_en[s]),
            .src_late   (id_src_late[s]),
            .src_reg    (id_src_reg[s*REG_W +: REG_W]),
            .id_is_mla  (id_is_mla),
            .hit        (hit)
        );
        assign stall_vec[s] = (hit == HIT_STALL);
        assign feed_vec[s]  = (hit == HIT_FEED);
    end

    mhz_verdict_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .id_valid    (id_valid),
        .stall_vec   (stall_vec),
        .feed_vec    (feed_vec),
        .stall       (stall),
        .acc_fwd_sel (acc_fwd_sel)
    );
endmodule

// File: rtl/mhz_checker.sv
// Module: temporal checks on the multiply interlock detector, bound to the top.
// Assumes: same parameters as the top it observes.
module mhz_checker #(
    parameter int REG_W   = 4,
    parameter int NUM_SRC = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     id_valid,
    input logic                     id_is_mul,
    input logic                     id_has_dst,
    input logic [REG_W-1:0]         id_dst,
    input logic [NUM_SRC-1:0]       id_src_en,
    input logic [NUM_SRC-1:0]       id_src_late,
    input logic [NUM_SRC*REG_W-1:0] id_src_reg,
    input logic                     stall,
    input logic                     acc_fwd_sel
);
    localparam logic [REG_W-1:0] PC_REG = {REG_W{1'b1}};

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !stall);

    // R2
    early_read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(id_valid && id_is_mul && id_has_dst && !stall
                               && id_dst != PC_REG)
         && id_valid && id_src_en[0] && !id_src_late[0]
         && id_src_reg[REG_W-1:0] == $past(id_dst)) |-> stall);

    // R7
    non_producer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!id_is_mul || !id_has_dst || id_dst == PC_REG) |-> !stall);

    // R8
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!stall && !acc_fwd_sel));

    // R10
    feed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fwd_sel |-> !stall);
endmodule

bind mul_hazard_unit mhz_checker #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_valid    (id_valid),
    .id_is_mul   (id_is_mul),
    .id_has_dst  (id_has_dst),
    .id_dst      (id_dst),
    .id_src_en   (id_src_en),
    .id_src_late (id_src_late),
    .id_src_reg  (id_src_reg),
    .stall       (stall),
    .acc_fwd_sel (acc_fwd_sel)
);

// File: tb/mul_hazard_unit_bench.sv
module mul_hazard_unit_bench;
    localparam int REG_W   = 4;
    localparam int NUM_SRC = 3;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     id_valid = 1'b0;
    logic                     id_is_mul = 1'b0;
    logic                     id_is_mla = 1'b0;
    logic                     id_has_dst = 1'b0;
    logic [REG_W-1:0]         id_dst = '0;
    logic [NUM_SRC-1:0]       id_src_en = '0;
    logic [NUM_SRC-1:0]       id_src_late = '0;
    logic [NUM_SRC*REG_W-1:0] id_src_reg = '0;
    logic                     stall;
    logic                     acc_fwd_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state: the previous accepted instruction, if it is a tracked multiply.
    bit ref_prev_valid = 0;
    int ref_prev_dst = 0;
    int feed_seen = 0;

    always #5 clk = ~clk;

    mul_hazard_unit #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_mul_hazard_unit (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_is_mul(id_is_mul),
        .id_is_mla(id_is_mla), .id_has_dst(id_has_dst), .id_dst(id_dst),
        .id_src_en(id_src_en), .id_src_late(id_src_late), .id_src_reg(id_src_reg),
        .stall(stall), .acc_fwd_sel(acc_fwd_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one instruction until the model says it is accepted; return stall cycles.
    task automatic run_instr(input string req, input bit v, input bit mul, input bit mla,
                             input bit hd, input int dst,
                             input bit e0, input bit e1, input bit e2, input bit l2,
                             input int r0, input int r1, input int r2,
                             output int stalls);
        bit exp_stall;
        bit exp_feed;
        bit hit0, hit1, hit2;
        stalls = 0;
        do begin
            @(negedge clk);
            id_valid = v; id_is_mul = mul; id_is_mla = mla; id_has_dst = hd;
            id_dst = dst[REG_W-1:0];
            id_src_en = {e2, e1, e0};
            id_src_late = {l2, 1'b0, 1'b0};
            id_src_reg = {r2[REG_W-1:0], r1[REG_W-1:0], r0[REG_W-1:0]};
            #1;
            hit0 = ref_prev_valid && e0 && r0 == ref_prev_dst;
            hit1 = ref_prev_valid && e1 && r1 == ref_prev_dst;
            hit2 = ref_prev_valid && e2 && r2 == ref_prev_dst;
            exp_stall = v && (hit0 || hit1 || (hit2 && !(mla && l2)));
            exp_feed  = v && !exp_stall && hit2 && mla && l2;
            check({req, " stall"}, int'(stall), int'(exp_stall));
            check({req, " acc_fwd_sel (R10)"}, int'(acc_fwd_sel), int'(exp_feed));
            if (acc_fwd_sel) feed_seen++;
            @(posedge clk);
            if (exp_stall) begin
                stalls++;
                ref_prev_valid = 0;
            end else begin
                ref_prev_valid = v && mul && hd && dst != 15;
                ref_prev_dst = dst;
            end
        end while (exp_stall && stalls < 4);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int f0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: first instruction after reset reads r0, nothing recorded
        run_instr("R1", 1, 0, 0, 1, 4, 1, 1, 0, 0, 0, 3, 0, n);
        check("R1 pair stalls", n, 0);

        // R2 R6: MUL r0 then SUB r4 <- r0, r3
        run_instr("R2 mul", 1, 1, 0, 1, 0, 1, 1, 0, 0, 1, 2, 0, n);
        run_instr("R2", 1, 0, 0, 1, 4, 1, 1, 0, 0, 0, 3, 0, n);
        check("R2 pair stalls", n, 1);

        // R3 R6: MLA r0 then store r0 to [r8] (late data slot 2)
        run_instr("R3 mla", 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 2, 3, n);
        run_instr("R3", 1, 0, 0, 0, 0, 1, 0, 1, 1, 8, 0, 0, n);
        check("R3 pair stalls", n, 1);

        // R4: accumulator chain MLA r0 ; MLA r0 <- r3*r4 + r0
        run_instr("R4 mla", 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 2, 3, n);
        f0 = feed_seen;
        run_instr("R4", 1, 1, 1, 1, 0, 1, 1, 1, 1, 3, 4, 0, n);
        check("R4 pair stalls", n, 0);
        check("R4 feedback seen", feed_seen - f0, 1);

        // unrelated pair: MUL r5 ; ADD r6 <- r7, r8
        run_instr("R2 unrel mul", 1, 1, 0, 1, 5, 1, 1, 0, 0, 1, 2, 0, n);
        run_instr("R2 unrel", 1, 0, 0, 1, 6, 1, 1, 0, 0, 7, 8, 0, n);
        check("R2 unrelated pair stalls", n, 0);

        // R5: chained MLA also reading r0 as A operand
        run_instr("R5 mla", 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 2, 3, n);
        run_instr("R5", 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 4, 0, n);
        check("R5 pair stalls", n, 1);

        // R7: MUL to r15 then read r15
        run_instr("R7 pc mul", 1, 1, 0, 1, 15, 1, 1, 0, 0, 1, 2, 0, n);
        run_instr("R7 pc", 1, 0, 0, 1, 4, 1, 1, 0, 0, 15, 3, 0, n);
        check("R7 pc pair stalls", n, 0);
        // R7: non-multiply producer ADD r0 then SUB reading r0
        run_instr("R7 add", 1, 0, 0, 1, 0, 1, 1, 0, 0, 1, 2, 0, n);
        run_instr("R7 nonmul", 1, 0, 0, 1, 4, 1, 1, 0, 0, 0, 3, 0, n);
        check("R7 nonmul pair stalls", n, 0);
        // R7: multiply flagged without destination
        run_instr("R7 nodst mul", 1, 1, 0, 0, 0, 1, 1, 0, 0, 1, 2, 0, n);
        run_instr("R7 nodst", 1, 0, 0, 1, 4, 1, 1, 0, 0, 0, 3, 0, n);
        check("R7 nodst pair stalls", n, 0);

        // R8: MUL r0 ; unrelated ; SUB reading r0
        run_instr("R8 mul", 1, 1, 0, 1, 0, 1, 1, 0, 0, 1, 2, 0, n);
        run_instr("R8 gap", 1, 0, 0, 1, 9, 1, 1, 0, 0, 7, 8, 0, n);
        run_instr("R8", 1, 0, 0, 1, 4, 1, 1, 0, 0, 0, 3, 0, n);
        check("R8 distance-two stalls", n, 0);

        // R9: MUL r0 ; invalid slot with matching fields ; SUB r0
        run_instr("R9 mul", 1, 1, 0, 1, 0, 1, 1, 0, 0, 1, 2, 0, n);
        run_instr("R9", 0, 1, 0, 1, 0, 1, 1, 0, 0, 0, 0, 0, n);
        check("R9 invalid stalls", n, 0);
        run_instr("R9 after", 1, 0, 0, 1, 4, 1, 1, 0, 0, 0, 3, 0, n);
        check("R9 after-bubble stalls", n, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule